// File: doc/BRIEF.md
# Edge-Triggered Set/Clear Gate with Force and Disable Policy

This block keeps one registered output bit. A chosen transition on a set input drives the bit high. A chosen transition on a clear input drives it low. Each input has its own transition selector: rising, falling or both.

An enable input decides whether input transitions are acted on. While the block is disabled, a mode input fixes the output low, fixes it high, or leaves it where it was. Two single-cycle strobes drive the output high or low directly. The strobes override input transitions and the disable mode.

Transitions are found by comparing each input with its value sampled at the previous clock. That history is kept every cycle, even while the block is disabled. The configuration inputs are applied in the same cycle they are presented, so a selector change takes effect together with any transition on that cycle. The bit changes on the clock edge after the cycle that requests it.

Top module: `srg_gate`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0 and both input histories are 0. If `set_i` is already 1 in the first clock after reset, that counts as a rising transition.
- R2: Encoding of `set_edge_cfg`: 0 = rising, 1 = falling, 2 = either, 3 = none. A qualifying transition on `set_i` while enabled, with no strobe, makes `q_o` 1 after the next clock edge.
- R3: `clr_edge_cfg` uses the same encoding as R2. A qualifying transition on `clr_i` while enabled, with no strobe, makes `q_o` 0 after the next clock edge.
- R4: When set and clear transitions both qualify in the same cycle, `q_o` becomes 0.
- R5: While `en_i` is 0, input transitions are ignored. The encoding of `dis_mode_cfg` is 0 = drive `q_o` low, 1 = drive it high, 2 or 3 = hold it.
- R6: `force_hi_i` drives `q_o` to 1 and `force_lo_i` drives it to 0. If both are high, `q_o` becomes 0. Strobes override input transitions and the disable mode in their cycle.
- R7: A transition is judged against the selector value present in the same cycle. Switching from rising to falling during a rising transition ignores that transition. Switching to falling during a falling transition honours it.
- R8: Input history keeps updating while the block is disabled. A level change made during the disabled time does not count as a transition when `en_i` returns to 1.
- R9: When the block is enabled, with no strobe and no qualifying transition, `q_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| en_i | input | 1 | When high, input transitions are acted on |
| set_i | input | 1 | Set request input |
| clr_i | input | 1 | Clear request input |
| set_edge_cfg | input | 2 | Transition selector for `set_i` |
| clr_edge_cfg | input | 2 | Transition selector for `clr_i` |
| dis_mode_cfg | input | 2 | Output policy while disabled |
| force_hi_i | input | 1 | One-cycle strobe that drives the output high |
| force_lo_i | input | 1 | One-cycle strobe that drives the output low |
| q_o | output | 1 | Registered gate output |

## Verification
Each selector value is tried with single rising and falling pulses on each input. This separates rising-only, falling-only, either and none. Set and clear transitions are then placed in the same cycle, and strobes are placed on top of transitions and on top of each disable mode, which shows the priority order. Selector writes are timed to coincide with transitions, and inputs are moved while the block is disabled, which checks same-cycle configuration and continuous history. A long pseudo-random run then checks every combination against the reference model, one clock at a time.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
package srg_pkg;
  localparam int unsigned EDGE_CFG_W = 2;
  localparam int unsigned DIS_CFG_W  = 2;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned CH_SET     = 0;
  localparam int unsigned CH_CLR     = 1;

  typedef enum logic [EDGE_CFG_W-1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2,
    EDGE_NONE = 2'd3
  } edge_sel_e;

  typedef enum logic [DIS_CFG_W-1:0] {
    DIS_LOW   = 2'd0,
    DIS_HIGH  = 2'd1,
    DIS_HOLD  = 2'd2,
    DIS_HOLD2 = 2'd3
  } dis_mode_e;
endpackage

// File: rtl/srg_edge_unit.sv
`timescale 1ns/1ps
module srg_edge_unit
  import srg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  din,
  input  logic [EDGE_CFG_W-1:0] sel,
  output logic                  hit
);
  logic prev_q;
  logic prev_d;
  logic prev_en;
  logic rise;
  logic fall;

  // history is refreshed every cycle, enabled or not
  assign prev_en = 1'b1;
  assign prev_d  = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  assign rise = din & ~prev_q;
  assign fall = ~din & prev_q;

  always_comb begin
    unique case (edge_sel_e'(sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      EDGE_NONE: hit = 1'b0;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/srg_next_logic.sv
`timescale 1ns/1ps
module srg_next_logic
  import srg_pkg::*;
(
  input  logic                 q_cur,
  input  logic                 en,
  input  logic                 set_hit,
  input  logic                 clr_hit,
  input  logic                 force_hi,
  input  logic                 force_lo,
  input  logic [DIS_CFG_W-1:0] dis_mode,
  output logic                 q_nxt,
  output logic                 q_load
);
  always_comb begin
    q_nxt  = q_cur;
    q_load = 1'b0;
    if (force_lo) begin
      q_nxt  = 1'b0;
      q_load = 1'b1;
    end else if (force_hi) begin
      q_nxt  = 1'b1;
      q_load = 1'b1;
    end else if (!en) begin
      unique case (dis_mode_e'(dis_mode))
        DIS_LOW:  begin q_nxt = 1'b0; q_load = 1'b1; end
        DIS_HIGH: begin q_nxt = 1'b1; q_load = 1'b1; end
        default:  begin q_nxt = q_cur; q_load = 1'b0; end
      endcase
    end else if (clr_hit) begin
      q_nxt  = 1'b0;
      q_load = 1'b1;
    end else if (set_hit) begin
      q_nxt  = 1'b1;
      q_load = 1'b1;
    end
  end
endmodule

// File: rtl/srg_gate.sv
`timescale 1ns/1ps
module srg_gate
  import srg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic                  set_i,
  input  logic                  clr_i,
  input  logic [EDGE_CFG_W-1:0] set_edge_cfg,
  input  logic [EDGE_CFG_W-1:0] clr_edge_cfg,
  input  logic [DIS_CFG_W-1:0]  dis_mode_cfg,
  input  logic                  force_hi_i,
  input  logic                  force_lo_i,
  output logic                  q_o
);
  logic [NUM_CH-1:0]                 ch_din;
  logic [NUM_CH-1:0][EDGE_CFG_W-1:0] ch_sel;
  logic [NUM_CH-1:0]                 ch_hit;
  logic q_q;
  logic q_d;
  logic q_en;

  assign ch_din[CH_SET] = set_i;
  assign ch_din[CH_CLR] = clr_i;
  assign ch_sel[CH_SET] = set_edge_cfg;
  assign ch_sel[CH_CLR] = clr_edge_cfg;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    srg_edge_unit u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ch_din[g]),
      .sel   (ch_sel[g]),
      .hit   (ch_hit[g])
    );
  end

  srg_next_logic u_next (
    .q_cur    (q_q),
    .en       (en_i),
    .set_hit  (ch_hit[CH_SET]),
    .clr_hit  (ch_hit[CH_CLR]),
    .force_hi (force_hi_i),
    .force_lo (force_lo_i),
    .dis_mode (dis_mode_cfg),
    .q_nxt    (q_d),
    .q_load   (q_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/srg_gate_chk.sv
`timescale 1ns/1ps
module srg_gate_chk
  import srg_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en_i,
  input logic                  set_i,
  input logic                  clr_i,
  input logic [EDGE_CFG_W-1:0] set_edge_cfg,
  input logic [EDGE_CFG_W-1:0] clr_edge_cfg,
  input logic [DIS_CFG_W-1:0]  dis_mode_cfg,
  input logic                  force_hi_i,
  input logic                  force_lo_i,
  input logic                  q_o
);
  logic armed;
  logic no_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign no_force = !force_hi_i && !force_lo_i;

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_low_chk: assert (q_o == 1'b0);
  end

  // R6
  force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_lo_i |=> !q_o);

  // R6
  force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_hi_i && !force_lo_i |=> q_o);

  // R5
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && no_force && dis_mode_cfg == 2'd0 |=> !q_o);

  // R5
  dis_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && no_force && dis_mode_cfg == 2'd1 |=> q_o);

  // R5
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && no_force && dis_mode_cfg[1] |=> $stable(q_o));

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && en_i && no_force && $stable(set_i) && $stable(clr_i) |=> $stable(q_o));

  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && en_i && no_force && $rose(clr_i) && clr_edge_cfg == 2'd0 |=> !q_o);

  // R2
  set_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && en_i && no_force && $stable(clr_i) && $rose(set_i) && set_edge_cfg == 2'd0 |=> q_o);
endmodule

bind srg_gate srg_gate_chk u_chk (.*);

// File: tb/sim_srg_gate.sv
`timescale 1ns/1ps
module sim_srg_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, set_i = 1'b0, clr_i = 1'b0;
  logic [1:0] set_edge_cfg = 2'd0, clr_edge_cfg = 2'd0, dis_mode_cfg = 2'd0;
  logic force_hi_i = 1'b0, force_lo_i = 1'b0;
  logic q_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q = 1'b0;
  bit prv_s = 1'b0;
  bit prv_c = 1'b0;

  always #2.5 clk = ~clk;

  srg_gate u0 (.*);

  function automatic bit qual(int cfg, bit cur, bit prv);
    case (cfg)
      0: return cur && !prv;
      1: return !cur && prv;
      2: return cur != prv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag);
    n_cmp++;
    if (q_o !== exp_q) begin
      n_bad++;
      $display("FAIL %s t=%0t q_o=%b expected=%b", tag, $time, q_o, exp_q);
    end
  endtask

  // drive one cycle, run the model, compare after the edge
  task automatic cyc(string tag, bit en, bit s, bit c, int se, int ce, int dm,
                     bit fh = 0, bit fl = 0);
    bit nq;
    en_i = en; set_i = s; clr_i = c;
    set_edge_cfg = 2'(se); clr_edge_cfg = 2'(ce); dis_mode_cfg = 2'(dm);
    force_hi_i = fh; force_lo_i = fl;
    nq = exp_q;
    if (fl) nq = 0;
    else if (fh) nq = 1;
    else if (!en) begin
      if (dm == 0) nq = 0;
      else if (dm == 1) nq = 1;
    end else if (qual(ce, c, prv_c)) nq = 0;
    else if (qual(se, s, prv_s)) nq = 1;
    @(posedge clk);
    #1;
    exp_q = nq; prv_s = s; prv_c = c;
    check(tag);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired q_o=%b expected=done", q_o);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad + 0);
    $finish;
  end

  initial begin
    set_i = 1'b1;
    en_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    rst_n = 1'b1;
    // R1: input high at first clock counts as rising
    cyc("R1 first-high", 1, 1, 0, 0, 0, 0);
    cyc("R9 hold", 1, 1, 0, 0, 0, 0);
    // R3 clear rising, then falling-only ignores rise
    cyc("R3 clr rise", 1, 1, 1, 0, 0, 0);
    cyc("R3 hold", 1, 1, 1, 0, 0, 0);
    // R2 falling select
    cyc("R2 set fall", 1, 0, 1, 1, 0, 0);
    cyc("R3 clr fall", 1, 0, 0, 1, 1, 0);
    cyc("R2 either rise", 1, 1, 0, 2, 1, 0);
    cyc("R3 either", 1, 1, 1, 2, 2, 0);
    cyc("R2 either fall", 1, 0, 1, 2, 2, 0);
    cyc("R2 none", 1, 1, 1, 3, 3, 0);
    cyc("R2 none", 1, 0, 0, 3, 3, 0);
    // R4 simultaneous
    cyc("R4 both", 1, 1, 1, 0, 0, 0);
    cyc("R2 set", 1, 0, 1, 1, 0, 0);
    cyc("R4 both fall", 1, 1, 0, 0, 1, 0);
    // R5 disable modes
    cyc("R5 low", 0, 0, 0, 0, 0, 0);
    cyc("R5 high", 0, 1, 0, 0, 0, 1);
    cyc("R5 hold", 0, 0, 1, 2, 0, 2);
    cyc("R5 hold3", 0, 1, 0, 2, 2, 3);
    // R6 force
    cyc("R6 force lo", 1, 0, 0, 2, 0, 0, 0, 1);
    cyc("R6 force hi over clr", 1, 0, 1, 0, 0, 0, 1, 0);
    cyc("R6 both", 1, 1, 0, 0, 0, 0, 1, 1);
    cyc("R6 hi while dis low", 0, 1, 0, 0, 0, 0, 1, 0);
    cyc("R5 back low", 0, 0, 0, 0, 0, 0);
    // R7 selector change with edge
    cyc("R7 idle", 1, 0, 0, 0, 0, 0);
    cyc("R7 rise ignored", 1, 1, 0, 1, 0, 0);
    cyc("R7 fall honoured", 1, 0, 0, 1, 0, 0);
    cyc("R7 clear", 1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R7 rise", 1, 1, 0, 0, 0, 0);
    cyc("R7 clear", 1, 1, 0, 0, 0, 0, 0, 1);
    cyc("R7 fall with switch", 1, 0, 0, 1, 0, 0);
    // R8 history during disable
    cyc("R8 clear", 1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R8 dis rise", 0, 1, 0, 0, 0, 2);
    cyc("R8 dis hold", 0, 1, 0, 0, 0, 2);
    cyc("R8 reenable", 1, 1, 0, 0, 0, 0);
    cyc("R8 still", 1, 1, 0, 0, 0, 0);
    // R9 random sweep
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom;
      cyc("R9 sweep", (r % 5) != 0, r[3], r[4], (r >> 5) % 4, (r >> 7) % 4,
          (r >> 9) % 4, (r % 23) == 0, (r % 29) == 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule